// File: doc/BRIEF.md
# CAN Remote Request Auto-Responder

This block sits beside the receive path of a CAN controller and handles remote requests without software. It keeps a small table of transmit buffers. Each entry holds an identifier, a format flag (standard or extended), a respond-enable flag and a valid flag. When the receiver signals that a frame is complete, the block looks at that frame. If the frame is a remote request, the block compares its identifier exactly against every eligible buffer. It then asks the transmitter to send the lowest-numbered buffer that matches.

A remote request is never kept as received data. For every remote frame, the block raises a store-inhibit signal towards the receive buffers, whether or not any buffer matches. Data frames pass through untouched. Acceptance masks play no part here: every identifier bit has to agree. All outputs are registered and appear in the clock cycle after the frame-complete strobe.

Top module: `rtr_autoreply`

## Requirements
- R1: In the cycle after `rx_done` is sampled high with `rx_rtr`=1, `store_inhibit` is 1, whether or not any buffer matches.
- R2: In the cycle after `rx_done` is sampled high with `rx_rtr`=0, both `store_inhibit` and `tx_req` are 0, even when a buffer would match.
- R3: A buffer whose respond-enable flag is 0 never triggers `tx_req`.
- R4: Matching uses no mask. An extended frame (`rx_ide`=1) matches only if all 29 bits of `rx_id` equal the buffer identifier. A single differing bit prevents the match.
- R5: A frame matches only buffers whose format flag equals `rx_ide` (0 = standard, 1 = extended).
- R6: For standard frames, only bits [10:0] of `rx_id` and of the buffer identifier are compared. Bits [28:11] on either side are ignored.
- R7: When several buffers match, `tx_idx` names the lowest-numbered one. `tx_req` is high for exactly one cycle per matching remote frame and is never high in a cycle that does not follow a sampled `rx_done`.
- R8: A buffer is excluded from matching if it is not valid, or if its `tx_busy` bit is 1 in the cycle where `rx_done` is sampled.
- R9: During and right after reset, `tx_req`, `tx_idx` and `store_inhibit` are 0, and every buffer is invalid, so a remote frame triggers nothing.
- R10: A configuration write (`cfg_we`=1) updates entry `cfg_idx` at the clock edge. A frame whose `rx_done` is sampled on that same edge is matched against the previous contents. Frames on later edges see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one buffer entry |
| cfg_idx | input | IDX_W | Entry to write |
| cfg_id | input | 29 | Identifier; standard identifiers use bits [10:0] |
| cfg_ext | input | 1 | Format: 1 = extended, 0 = standard |
| cfg_resp_en | input | 1 | Answer remote requests for this entry |
| cfg_valid | input | 1 | Entry takes part in matching |
| tx_busy | input | NUM_BUF | Per-buffer flag: transmission in progress |
| rx_done | input | 1 | One-cycle strobe: a frame has been fully received |
| rx_id | input | 29 | Received identifier |
| rx_ide | input | 1 | Received format: 1 = extended |
| rx_rtr | input | 1 | Received frame is a remote request |
| tx_req | output | 1 | One-cycle request to transmit buffer `tx_idx` |
| tx_idx | output | IDX_W | Buffer chosen for the response |
| store_inhibit | output | 1 | Tells the receive path not to store the frame |

## Verification
The case hardest to reach from the ports is several buffers sharing one identifier while the lower-numbered ones are busy, invalid or disarmed, so the choice has to skip past them. A second hard case is a configuration write landing on the same edge as the frame it would affect. Random stimulus draws identifiers mostly from the live table and busy masks at about one bit in four, so overlapping hits are common. Directed sequences load duplicate identifiers, toggle the busy bits, and present a write together with a frame strobe.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
    localparam int ID_W  = 29;
    localparam int STD_W = 11;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            ext;
        logic            resp_en;
        logic            valid;
    } rtr_buf_t;
endpackage

// File: rtl/rtr_match_cell.sv
module rtr_match_cell
    import rtr_pkg::*;
(
    input  rtr_buf_t        entry,
    input  logic            busy,
    input  logic [ID_W-1:0] rx_id,
    input  logic            rx_ide,
    output logic            hit
);
    logic id_eq;

    always_comb begin
        if (rx_ide) begin
            id_eq = (rx_id == entry.id);
        end else begin
            id_eq = (rx_id[STD_W-1:0] == entry.id[STD_W-1:0]);
        end
        hit = entry.valid && entry.resp_en && !busy
              && (entry.ext == rx_ide) && id_eq;
    end
endmodule

// File: rtl/rtr_prio_pick.sv
module rtr_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rtr_autoreply.sv
module rtr_autoreply
    import rtr_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [ID_W-1:0]    cfg_id,
    input  logic               cfg_ext,
    input  logic               cfg_resp_en,
    input  logic               cfg_valid,
    input  logic [NUM_BUF-1:0] tx_busy,
    input  logic               rx_done,
    input  logic [ID_W-1:0]    rx_id,
    input  logic               rx_ide,
    input  logic               rx_rtr,
    output logic               tx_req,
    output logic [IDX_W-1:0]   tx_idx,
    output logic               store_inhibit
);
    localparam logic [IDX_W:0] NB = NUM_BUF[IDX_W:0];

    typedef struct packed {
        rtr_buf_t [NUM_BUF-1:0] tbl;
        logic                   req;
        logic [IDX_W-1:0]       idx;
        logic                   inh;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_BUF-1:0] hit_vec;
    logic               any_hit;
    logic [IDX_W-1:0]   pick_idx;

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_cell
        rtr_match_cell u_cell (
            .entry  (s_q.tbl[g]),
            .busy   (tx_busy[g]),
            .rx_id  (rx_id),
            .rx_ide (rx_ide),
            .hit    (hit_vec[g])
        );
    end

    rtr_prio_pick #(.N(NUM_BUF), .IDX_W(IDX_W)) u_pick (
        .req (hit_vec),
        .any (any_hit),
        .idx (pick_idx)
    );

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        s_d.inh = 1'b0;
        if (rx_done) begin
            s_d.inh = rx_rtr;
            if (rx_rtr && any_hit) begin
                s_d.req = 1'b1;
                s_d.idx = pick_idx;
            end
        end
        if (cfg_we && ({1'b0, cfg_idx} < NB)) begin
            s_d.tbl[cfg_idx].id      = cfg_id;
            s_d.tbl[cfg_idx].ext     = cfg_ext;
            s_d.tbl[cfg_idx].resp_en = cfg_resp_en;
            s_d.tbl[cfg_idx].valid   = cfg_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_req        = s_q.req;
    assign tx_idx        = s_q.idx;
    assign store_inhibit = s_q.inh;
endmodule

// File: rtl/rtr_autoreply_chk.sv
module rtr_autoreply_chk #(
    parameter int NUM_BUF = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_BUF-1:0] tx_busy,
    input logic               rx_done,
    input logic               rx_rtr,
    input logic               tx_req,
    input logic [IDX_W-1:0]   tx_idx,
    input logic               store_inhibit
);
    logic [NUM_BUF-1:0] busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= tx_busy;
    end

    // R1
    rtr_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_rtr) |=> store_inhibit);

    // R2
    data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_rtr) |=> (!store_inhibit && !tx_req));

    // R7
    req_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> ($past(rx_done && rx_rtr) && store_inhibit));

    // R7
    no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> !tx_req);

    // R8
    busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> !busy_q[tx_idx]);
endmodule

bind rtr_autoreply rtr_autoreply_chk #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_busy       (tx_busy),
    .rx_done       (rx_done),
    .rx_rtr        (rx_rtr),
    .tx_req        (tx_req),
    .tx_idx        (tx_idx),
    .store_inhibit (store_inhibit)
);

// File: tb/rtr_autoreply_tb.sv
module rtr_autoreply_tb;
    localparam int NB = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [IW-1:0] cfg_idx;
    logic [28:0]   cfg_id;
    logic          cfg_ext, cfg_resp_en, cfg_valid;
    logic [NB-1:0] tx_busy;
    logic          rx_done;
    logic [28:0]   rx_id;
    logic          rx_ide, rx_rtr;
    logic          tx_req;
    logic [IW-1:0] tx_idx;
    logic          store_inhibit;

    int n_cmp  = 0;
    int n_fail = 0;

    logic [28:0] m_id  [NB];
    logic        m_ext [NB];
    logic        m_en  [NB];
    logic        m_val [NB];

    always #2.5 clk = ~clk;

    rtr_autoreply #(.NUM_BUF(NB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_id(cfg_id), .cfg_ext(cfg_ext),
        .cfg_resp_en(cfg_resp_en), .cfg_valid(cfg_valid),
        .tx_busy(tx_busy), .rx_done(rx_done), .rx_id(rx_id), .rx_ide(rx_ide),
        .rx_rtr(rx_rtr), .tx_req(tx_req), .tx_idx(tx_idx),
        .store_inhibit(store_inhibit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic buf_hit(input int i, input logic [28:0] id,
                                     input logic ide, input logic [NB-1:0] busy);
        logic same;
        same = ide ? (id == m_id[i]) : (id[10:0] == m_id[i][10:0]);
        return m_val[i] && m_en[i] && !busy[i] && (m_ext[i] == ide) && same;
    endfunction

    task automatic expect_of(input logic [28:0] id, input logic ide, input logic rtr,
                             input logic [NB-1:0] busy,
                             output logic e_req, output logic [IW-1:0] e_idx);
        e_req = 1'b0;
        e_idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (rtr && buf_hit(i, id, ide, busy)) begin
                e_req = 1'b1;
                e_idx = IW'(i);
            end
        end
    endtask

    task automatic set_buf(input int idx, input logic [28:0] id, input logic ext,
                           input logic en, input logic val);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_id = id;
        cfg_ext = ext; cfg_resp_en = en; cfg_valid = val;
        @(negedge clk);
        cfg_we = 1'b0;
        m_id[idx] = id; m_ext[idx] = ext; m_en[idx] = en; m_val[idx] = val;
    endtask

    task automatic send(input logic [28:0] id, input logic ide, input logic rtr,
                        input logic [NB-1:0] busy, input string req);
        logic          e_req;
        logic [IW-1:0] e_idx;
        expect_of(id, ide, rtr, busy, e_req, e_idx);
        rx_id = id; rx_ide = ide; rx_rtr = rtr; tx_busy = busy; rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0; tx_busy = '0;
        check({req, " inhibit"}, 32'(store_inhibit), 32'(rtr));
        check({req, " req"}, 32'(tx_req), 32'(e_req));
        if (e_req) check({req, " idx"}, 32'(tx_idx), 32'(e_idx));
        @(negedge clk);
        check("R7 single pulse", 32'(tx_req), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        logic          e_req;
        logic [IW-1:0] e_idx;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NB; i++) begin
            m_id[i] = '0; m_ext[i] = 1'b0; m_en[i] = 1'b0; m_val[i] = 1'b0;
        end
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_id = '0; cfg_ext = 1'b0;
        cfg_resp_en = 1'b0; cfg_valid = 1'b0; tx_busy = '0; rx_done = 1'b0;
        rx_id = '0; rx_ide = 1'b0; rx_rtr = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset req", 32'(tx_req), 32'h0);
        check("R9 reset idx", 32'(tx_idx), 32'h0);
        check("R9 reset inhibit", 32'(store_inhibit), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        send(29'h0, 1'b0, 1'b1, '0, "R9 empty table");
        send(29'h0, 1'b1, 1'b1, '0, "R1 no match still inhibits");

        // R4: one differing bit in an extended identifier
        set_buf(0, 29'h1ABC_DEF0, 1'b1, 1'b1, 1'b1);
        send(29'h1ABC_DEF0, 1'b1, 1'b1, '0, "R4 exact hit");
        send(29'h1ABC_DEF0 ^ 29'h1000_0000, 1'b1, 1'b1, '0, "R4 top bit differs");
        send(29'h1ABC_DEF1, 1'b1, 1'b1, '0, "R4 low bit differs");
        // R2: matching data frame is ignored
        send(29'h1ABC_DEF0, 1'b1, 1'b0, '0, "R2 data frame");
        // R5: standard frame vs extended buffer with equal low bits
        send(29'h0000_06F0, 1'b0, 1'b1, '0, "R5 format mismatch");
        // R6: standard buffer, upper bits differ on both sides
        set_buf(1, {18'h15555, 11'h123}, 1'b0, 1'b1, 1'b1);
        send({18'h0AAAA, 11'h123}, 1'b0, 1'b1, '0, "R6 std low bits only");
        send({18'h15555, 11'h122}, 1'b0, 1'b1, '0, "R6 std low bit differs");
        // R3: disarmed buffer
        set_buf(1, 29'h0000_0123, 1'b0, 1'b0, 1'b1);
        send(29'h0000_0123, 1'b0, 1'b1, '0, "R3 resp disabled");
        // R7 / R8: duplicates, priority, busy and invalid skipping
        set_buf(1, 29'h0555_1234, 1'b1, 1'b1, 1'b1);
        set_buf(2, 29'h0555_1234, 1'b1, 1'b1, 1'b1);
        set_buf(3, 29'h0555_1234, 1'b1, 1'b1, 1'b1);
        send(29'h0555_1234, 1'b1, 1'b1, 4'b0000, "R7 lowest wins");
        send(29'h0555_1234, 1'b1, 1'b1, 4'b0010, "R8 busy skipped");
        send(29'h0555_1234, 1'b1, 1'b1, 4'b1110, "R8 all busy");
        set_buf(1, 29'h0555_1234, 1'b1, 1'b1, 1'b0);
        send(29'h0555_1234, 1'b1, 1'b1, 4'b0000, "R8 invalid skipped");

        // R10: write on the same edge as the frame uses the old entry
        expect_of(29'h0555_1234, 1'b1, 1'b1, '0, e_req, e_idx);
        cfg_we = 1'b1; cfg_idx = 2'd1; cfg_id = 29'h0555_1234;
        cfg_ext = 1'b1; cfg_resp_en = 1'b1; cfg_valid = 1'b1;
        rx_id = 29'h0555_1234; rx_ide = 1'b1; rx_rtr = 1'b1; rx_done = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; rx_done = 1'b0;
        m_val[1] = 1'b1;
        check("R10 same edge req", 32'(tx_req), 32'(e_req));
        check("R10 same edge idx", 32'(tx_idx), 32'(e_idx));
        @(negedge clk);
        send(29'h0555_1234, 1'b1, 1'b1, '0, "R10 later edge");

        // Random mix (R1 R2 R3 R4 R5 R6 R7 R8)
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                int          k;
                logic        ext;
                logic [28:0] nid;
                k   = $urandom_range(0, NB - 1);
                ext = 1'($urandom);
                nid = 29'($urandom_range(0, 7)) | (29'($urandom) & 29'h1FFF_FFF8 & {29{ext}});
                if (!ext) nid[28:11] = 18'($urandom);
                set_buf(k, nid, ext, ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) != 0));
            end else begin
                int          k;
                logic [28:0] fid;
                logic        fide;
                logic [NB-1:0] bz;
                k    = $urandom_range(0, NB - 1);
                fid  = m_id[k];
                fide = m_ext[k];
                case ($urandom_range(0, 3))
                    0: fid = fid ^ (29'h1 << $urandom_range(0, 28));
                    1: fide = ~fide;
                    2: fid[28:11] = 18'($urandom);
                    default: ;
                endcase
                for (int b = 0; b < NB; b++) bz[b] = ($urandom_range(0, 3) == 0);
                send(fid, fide, ($urandom_range(0, 4) != 0), bz, "R7 random");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule